// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns one transfer request from a processor core into a bus transaction on a time-multiplexed bus. The bus has a 20-bit address, and its low 16 lines also carry the data. The core sends an address, write data, a cycle kind and a size. The block then launches the cycle and steps through the T-states T1, T2, T3, optional wait states (TW) and T4. It drives the address latch pulse, the read, write and acknowledge strobes, the two bank-select signals and a 3-bit status code. It adds a wait state for every clock in which the addressed device holds READY low.

A word access at an odd address becomes two byte cycles. The first cycle moves the low-order byte on the upper lane. The second cycle runs at the next address and moves the high-order byte on the lower lane. The status code of the second cycle already appears during T4 of the first cycle. When the last T4 ends, the block returns a one-clock response carrying the assembled read data.

The request side is a valid/ready handshake. `req_ready` is high only while no transaction is in progress, and a request transfers on a clock where both `req_valid` and `req_ready` are high. The response has no back-pressure: `rsp_valid` lasts exactly one clock, and the core must take `rsp_rdata` in that clock. Each clock spent in a wait state stretches the transaction by one clock.

Top module: `bus_cycle_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. After an accepted request it drops on the next clock, stays low for the whole transaction, and is high again in the clock where `rsp_valid` is high.
- R2: The clock after acceptance is a launch clock. Each bus cycle then takes T1, T2, T3, T4, which is four clocks plus waits. `bus_ale` is high only in T1, for one clock, and no strobe is low in T1.
- R3: Each clock in which `bus_ready` is low at the end of T3 or of a wait state adds one wait state. The active strobe stays low through the wait states. The response arrives 2 + cycles*(4 + waits) clocks after acceptance.
- R4: Kind codes are 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read and 110 memory write. Kinds 001, 100 and 101 pull `bus_rd_n` low. Kinds 010 and 110 pull `bus_wr_n` low. Kind 000 pulls `bus_inta_n` low. The strobe is low during T2, T3 and the wait states only. Halt drives no strobe.
- R5: `bus_stat` carries the kind code in the launch clock, T1 and T2, and in T3 or a wait state while `bus_ready` is low. In T4 it shows the next cycle's code if a second byte cycle follows. At all other times it reads 111.
- R6: In T1, `bus_ad_out[19:16]` carries the address top bits for kinds 100, 101 and 110, and is 0 for every other kind. `bus_ad_out[15:1]` carries address bits 15..1, and `bus_ad_out[0]` carries the A0 bank signal.
- R7: The bank pair {`bus_bhe_n`, A0} in T1 is 00 for a whole word, 01 for the upper byte at an odd address, 10 for the lower byte at an even address and 11 for halt.
- R8: A word at an odd address with kind 001, 010, 101 or 110 runs as two cycles. The first is at the address with pair 01. The second is at the address plus one, modulo 2^20, with pair 10, and its T1 follows the first T4 directly.
- R9: Fetch and interrupt-acknowledge cycles are always one word cycle at the address with bit 0 cleared. A request of kind 111 runs as a halt cycle.
- R10: For writes, `bus_ad_oe` is high from T2 to T4 and `bus_ad_out[15:0]` carries the data. A whole word goes out unchanged. A byte cycle repeats the byte on both lanes: it is the low data byte, or the high data byte in the second half of a split. `bus_ad_oe` is low after T1 for all other kinds.
- R11: `bus_ad_in` is sampled at the end of each T4 of a read or acknowledge cycle. A whole word is returned as is. A single byte is taken from the enabled lane and zero-extended. A split word returns {second-cycle lower lane, first-cycle upper lane}. Writes and halt return 0, and `rsp_valid` is a single clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered by the core |
| req_ready | output | 1 | Block idle; request accepted when both are high |
| req_addr | input | 20 | Byte address of the transfer |
| req_wdata | input | 16 | Write data (low byte used for byte writes) |
| req_kind | input | 3 | Cycle kind code |
| req_word | input | 1 | 1 for a word transfer, 0 for a byte |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid |
| bus_ready | input | 1 | Device ready; low inserts wait states |
| bus_ad_out | output | 20 | Multiplexed address/data lines, driven value |
| bus_ad_oe | output | 1 | Output enable for bus_ad_out |
| bus_ad_in | input | 16 | Data lines as read from the bus |
| bus_ale | output | 1 | Address latch enable, high in T1 |
| bus_bhe_n | output | 1 | Active-low upper-bank enable, valid in T1 |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_inta_n | output | 1 | Active-low interrupt-acknowledge strobe |
| bus_stat | output | 3 | Cycle status code, 111 when passive |

## Verification
The bench tries every kind code, both sizes and both address parities, each with zero, one and two wait states. It also runs one read and one write of a word at the top address, whose split cycle wraps to address zero. Comparing byte and word requests at even and odd addresses separates the single-cycle paths from the split path, as seen in the lane choice, the bank pair and the response timing. The wait-state counts show that the status code turns passive only on the ready clock and that the strobe widens by one clock per wait. Running every kind shows that the upper address lines are gated correctly, that each kind raises only its own strobe, and that fetch and acknowledge cycles are forced to even addresses.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  // Cycle kind; the numeric value doubles as the bus status code.
  typedef enum logic [2:0] {
    K_INTA  = 3'b000,
    K_IORD  = 3'b001,
    K_IOWR  = 3'b010,
    K_HALT  = 3'b011,
    K_FETCH = 3'b100,
    K_MEMRD = 3'b101,
    K_MEMWR = 3'b110,
    K_NONE  = 3'b111
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LAUNCH, S_T1, S_T2, S_T3, S_TW, S_T4
  } tstate_e;

  typedef enum logic [1:0] {
    STB_NONE, STB_RD, STB_WR, STB_ACK
  } strobe_e;

  function automatic strobe_e strobe_of(kind_e k);
    case (k)
      K_IORD, K_FETCH, K_MEMRD: return STB_RD;
      K_IOWR, K_MEMWR:          return STB_WR;
      K_INTA:                   return STB_ACK;
      default:                  return STB_NONE;
    endcase
  endfunction

  function automatic logic drives_upper(kind_e k);
    return (k == K_FETCH) || (k == K_MEMRD) || (k == K_MEMWR);
  endfunction

endpackage

// File: rtl/bcs_plan.sv
module bcs_plan
  import bcs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          second,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [2:0]    kind_i,
  input  logic          word_i,
  output kind_e         kind_o,
  output logic          split_o,
  output logic [AW-2:0] cyc_hi_o,
  output logic [1:0]    bank_o,
  output logic [DW-1:0] lane_o
);
  localparam int HW = DW / 2;

  kind_e         k_q, k_n;
  logic [AW-1:0] a_q, ca;
  logic [DW-1:0] w_q;
  logic          word_q, aligned_n, rw_kind;

  always_comb begin
    k_n = kind_e'(kind_i);
    if (k_n == K_NONE) k_n = K_HALT;
    aligned_n = (k_n == K_FETCH) || (k_n == K_INTA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q    <= K_HALT;
      a_q    <= '0;
      w_q    <= '0;
      word_q <= 1'b0;
    end else if (load) begin
      k_q    <= k_n;
      a_q    <= aligned_n ? {addr_i[AW-1:1], 1'b0} : addr_i;
      w_q    <= wdata_i;
      word_q <= aligned_n | word_i;
    end
  end

  assign rw_kind  = (k_q == K_IORD) || (k_q == K_IOWR) ||
                    (k_q == K_MEMRD) || (k_q == K_MEMWR);
  assign split_o  = rw_kind && word_q && a_q[0];
  assign ca       = second ? a_q + AW'(1) : a_q;
  assign cyc_hi_o = ca[AW-1:1];
  assign kind_o   = k_q;

  always_comb begin
    lane_o = {w_q[HW-1:0], w_q[HW-1:0]};
    if (k_q == K_HALT) begin
      bank_o = 2'b11;
    end else if (split_o) begin
      bank_o = second ? 2'b10 : 2'b01;
      if (second) lane_o = {w_q[DW-1:HW], w_q[DW-1:HW]};
    end else if (word_q) begin
      bank_o = 2'b00;
      lane_o = w_q;
    end else begin
      bank_o = ca[0] ? 2'b01 : 2'b10;
    end
  end

endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fire,
  input  logic    ready,
  input  logic    split,
  output tstate_e st,
  output logic    second,
  output logic    more,
  output logic    done
);

  assign more = (st == S_T4) && split && !second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      second <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          second <= 1'b0;
          if (fire) st <= S_LAUNCH;
        end
        S_LAUNCH: st <= S_T1;
        S_T1:     st <= S_T2;
        S_T2:     st <= S_T3;
        S_T3, S_TW: st <= ready ? S_T4 : S_TW;
        S_T4: begin
          if (more) begin
            st     <= S_T1;
            second <= 1'b1;
          end else begin
            st     <= S_IDLE;
            second <= 1'b0;
            done   <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bcs_lanes.sv
module bcs_lanes
  import bcs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tstate_e       st,
  input  kind_e         kind,
  input  logic          more,
  input  logic          second,
  input  logic [AW-2:0] cyc_hi,
  input  logic [1:0]    bank,
  input  logic [DW-1:0] lane,
  input  logic          ready,
  input  logic [DW-1:0] ad_in,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe,
  output logic          ale,
  output logic          bhe_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          inta_n,
  output logic [2:0]    stat,
  output logic [DW-1:0] rdata
);
  localparam int HW = DW / 2;
  localparam int UW = AW - DW;

  strobe_e       sc;
  logic          strobe_ph, data_ph, wr_k, stat_on, capture;
  logic [UW-1:0] upper;
  logic [HW-1:0] pick;

  assign sc        = strobe_of(kind);
  assign strobe_ph = (st == S_T2) || (st == S_T3) || (st == S_TW);
  assign data_ph   = strobe_ph || (st == S_T4);
  assign wr_k      = (sc == STB_WR);
  assign upper     = drives_upper(kind) ? cyc_hi[AW-2:DW-1] : '0;

  always_comb begin
    ad_out = '0;
    if (st == S_T1)
      ad_out = {upper, cyc_hi[DW-2:0], bank[0]};
    else if (data_ph && wr_k)
      ad_out = {{UW{1'b0}}, lane};
  end

  assign ad_oe  = (st == S_T1) || (data_ph && wr_k);
  assign ale    = (st == S_T1);
  assign bhe_n  = (st == S_T1) ? bank[1] : 1'b1;
  assign rd_n   = !(strobe_ph && sc == STB_RD);
  assign wr_n   = !(strobe_ph && sc == STB_WR);
  assign inta_n = !(strobe_ph && sc == STB_ACK);

  // Status: early in the cycle, held while the device stalls, and
  // pre-announced in T4 when another byte cycle follows.
  assign stat_on = (st == S_LAUNCH) || (st == S_T1) || (st == S_T2) ||
                   (((st == S_T3) || (st == S_TW)) && !ready) || more;
  assign stat    = stat_on ? kind : K_NONE;

  assign capture = (st == S_T4) && ((sc == STB_RD) || (sc == STB_ACK));
  assign pick    = bank[0] ? ad_in[DW-1:HW] : ad_in[HW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (st == S_LAUNCH) begin
      rdata <= '0;
    end else if (capture) begin
      if (bank == 2'b00)
        rdata <= ad_in;
      else if (second)
        rdata[DW-1:HW] <= pick;
      else
        rdata <= {{HW{1'b0}}, pick};
    end
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [2:0]    req_kind,
  input  logic          req_word,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_ad_out,
  output logic          bus_ad_oe,
  input  logic [DW-1:0] bus_ad_in,
  output logic          bus_ale,
  output logic          bus_bhe_n,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic          bus_inta_n,
  output logic [2:0]    bus_stat
);

  tstate_e       st;
  kind_e         kind;
  logic          fire, second, more, split;
  logic [AW-2:0] cyc_hi;
  logic [1:0]    bank;
  logic [DW-1:0] lane;

  assign req_ready = (st == S_IDLE);
  assign fire      = req_valid && req_ready;

  bcs_plan #(.AW(AW), .DW(DW)) u_plan (
    .clk(clk), .rst_n(rst_n), .load(fire), .second(second),
    .addr_i(req_addr), .wdata_i(req_wdata), .kind_i(req_kind), .word_i(req_word),
    .kind_o(kind), .split_o(split), .cyc_hi_o(cyc_hi), .bank_o(bank), .lane_o(lane)
  );

  bcs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ready(bus_ready), .split(split),
    .st(st), .second(second), .more(more), .done(rsp_valid)
  );

  bcs_lanes #(.AW(AW), .DW(DW)) u_lanes (
    .clk(clk), .rst_n(rst_n), .st(st), .kind(kind), .more(more), .second(second),
    .cyc_hi(cyc_hi), .bank(bank), .lane(lane), .ready(bus_ready), .ad_in(bus_ad_in),
    .ad_out(bus_ad_out), .ad_oe(bus_ad_oe), .ale(bus_ale), .bhe_n(bus_bhe_n),
    .rd_n(bus_rd_n), .wr_n(bus_wr_n), .inta_n(bus_inta_n), .stat(bus_stat),
    .rdata(rsp_rdata)
  );

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       bus_ready,
  input logic       bus_ale,
  input logic       bus_rd_n,
  input logic       bus_wr_n,
  input logic       bus_inta_n,
  input logic [2:0] bus_stat
);

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);

  p_no_strobe_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && bus_wr_n && bus_inta_n));

  p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((!bus_rd_n || !bus_wr_n || !bus_inta_n) && !bus_ready) |=>
      ($stable(bus_rd_n) && $stable(bus_wr_n) && $stable(bus_inta_n)));

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!bus_rd_n, !bus_wr_n, !bus_inta_n}) <= 1);

  p_ale_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_stat != 3'b111));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind bus_cycle_seq bcs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .bus_ready(bus_ready), .bus_ale(bus_ale),
  .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_inta_n(bus_inta_n),
  .bus_stat(bus_stat)
);

// File: tb/bus_cycle_seq_test.sv
`timescale 1ns/1ps
module bus_cycle_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [2:0]  req_kind = '0;
  logic        req_word = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        bus_ready = 1'b1;
  logic [19:0] bus_ad_out;
  logic        bus_ad_oe;
  logic [15:0] bus_ad_in = '0;
  logic        bus_ale, bus_bhe_n, bus_rd_n, bus_wr_n, bus_inta_n;
  logic [2:0]  bus_stat;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bus_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_kind(req_kind), .req_word(req_word),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_ready(bus_ready),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_ale(bus_ale), .bus_bhe_n(bus_bhe_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_inta_n(bus_inta_n), .bus_stat(bus_stat)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(int c);
    return 16'(c * 32'h3C5A + 32'h9183);
  endfunction

  function automatic logic [1:0] exp_bank(int ek, bit split, bit eword, logic [19:0] ea, int c);
    if (ek == 3) return 2'b11;
    if (split) return (c == 1) ? 2'b01 : 2'b10;
    if (eword) return 2'b00;
    return ea[0] ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [15:0] exp_lane(bit split, bit eword, logic [15:0] wd, int c);
    if (split) return (c == 1) ? {wd[7:0], wd[7:0]} : {wd[15:8], wd[15:8]};
    if (eword) return wd;
    return {wd[7:0], wd[7:0]};
  endfunction

  task automatic run_txn(input int k, input bit w, input logic [19:0] a,
                         input logic [15:0] wd, input int waits);
    int ek, ncyc, p, ph, wc, c, nrd, nwr, nack, busy_rdy;
    bit fw, eword, rw, split, upper, rdcls, wrcls, rdone, pend_t4, is_t4, decided, finished;
    logic [19:0] ea, ca;
    logic [1:0]  b;
    logic [15:0] exp_rd;
    ek = (k == 7) ? 3 : k;
    fw = (ek == 0) || (ek == 4);
    ea = fw ? {a[19:1], 1'b0} : a;
    eword = fw ? 1'b1 : w;
    rw = (ek == 1) || (ek == 2) || (ek == 5) || (ek == 6);
    split = rw && eword && ea[0];
    ncyc = split ? 2 : 1;
    upper = (ek >= 4) && (ek <= 6);
    rdcls = (ek == 0) || (ek == 1) || (ek == 4) || (ek == 5);
    wrcls = (ek == 2) || (ek == 6);
    if (!rdcls) exp_rd = 16'h0;
    else if (split) exp_rd = {pat(2)[7:0], pat(1)[15:8]};
    else begin
      b = exp_bank(ek, split, eword, ea, 1);
      if (b == 2'b00) exp_rd = pat(1);
      else if (b == 2'b01) exp_rd = {8'h00, pat(1)[15:8]};
      else exp_rd = {8'h00, pat(1)[7:0]};
    end

    @(negedge clk);
    req_addr = a; req_wdata = wd; req_kind = 3'(k); req_word = w; req_valid = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R1 ready before request", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    p = 1; ph = 0; wc = 0; c = 0; nrd = 0; nwr = 0; nack = 0; busy_rdy = 0;
    rdone = 0; pend_t4 = 0; finished = 0;
    while (!finished && p < 100) begin
      if (p > 1) @(negedge clk);
      is_t4 = pend_t4; pend_t4 = 0; decided = 0;
      if (ph > 0) ph++;
      bus_ready = 1'b1;
      if (ph >= 3 && !rdone) begin
        decided = 1;
        if (wc == waits) begin rdone = 1; pend_t4 = 1; end
        else begin bus_ready = 1'b0; wc++; end
      end
      #1;
      if (!bus_rd_n) nrd++;
      if (!bus_wr_n) nwr++;
      if (!bus_inta_n) nack++;
      if (!rsp_valid && req_ready) busy_rdy++;
      if (p == 1) chk(bus_stat == 3'(ek), "R5 launch status", 32'(bus_stat), 32'(ek));
      if (decided) begin
        chk(bus_stat == (bus_ready ? 3'b111 : 3'(ek)), "R5 T3/wait status", 32'(bus_stat),
            32'(bus_ready ? 3'b111 : 3'(ek)));
        if (ph == 3) begin
          chk(bus_ad_oe == wrcls, "R10 output enable", 32'(bus_ad_oe), 32'(wrcls));
          if (wrcls)
            chk(bus_ad_out[15:0] == exp_lane(split, eword, wd, c), "R10 write lanes",
                32'(bus_ad_out[15:0]), 32'(exp_lane(split, eword, wd, c)));
        end
      end
      if (is_t4)
        chk(bus_stat == ((c < ncyc) ? 3'(ek) : 3'b111), "R5 R8 T4 status", 32'(bus_stat),
            32'((c < ncyc) ? 3'(ek) : 3'b111));
      if (bus_ale) begin
        c++;
        ca = (c == 1) ? ea : ea + 20'd1;
        b = exp_bank(ek, split, eword, ea, c);
        chk(p == 2 + (c - 1) * (4 + waits), "R2 R8 T1 position", 32'(p), 32'(2 + (c - 1) * (4 + waits)));
        chk(bus_ad_out == {upper ? ca[19:16] : 4'h0, ca[15:1], b[0]}, "R6 R9 T1 address",
            32'(bus_ad_out), 32'({upper ? ca[19:16] : 4'h0, ca[15:1], b[0]}));
        chk({bus_bhe_n, bus_ad_out[0]} == b, "R7 bank pair", 32'({bus_bhe_n, bus_ad_out[0]}), 32'(b));
        chk(bus_stat == 3'(ek), "R5 R9 T1 status", 32'(bus_stat), 32'(ek));
        ph = 1; rdone = 0; wc = 0;
        bus_ad_in = pat(c);
      end
      if (rsp_valid) begin
        finished = 1;
        chk(p == 2 + ncyc * (4 + waits), "R2 R3 latency", 32'(p), 32'(2 + ncyc * (4 + waits)));
        chk(rsp_rdata == exp_rd, "R11 read data", 32'(rsp_rdata), 32'(exp_rd));
        chk(c == ncyc, "R8 cycle count", 32'(c), 32'(ncyc));
        chk(nrd == ((ek == 1 || ek == 4 || ek == 5) ? ncyc * (2 + waits) : 0), "R4 R3 read strobe",
            32'(nrd), 32'((ek == 1 || ek == 4 || ek == 5) ? ncyc * (2 + waits) : 0));
        chk(nwr == (wrcls ? ncyc * (2 + waits) : 0), "R4 write strobe",
            32'(nwr), 32'(wrcls ? ncyc * (2 + waits) : 0));
        chk(nack == ((ek == 0) ? (2 + waits) : 0), "R4 ack strobe",
            32'(nack), 32'((ek == 0) ? (2 + waits) : 0));
        chk(req_ready == 1'b1 && busy_rdy == 0, "R1 ready only when idle",
            32'(busy_rdy), 32'd0);
      end
      p++;
    end
    if (!finished) chk(1'b0, "R2 no response", 32'(p), 32'd0);
    @(negedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R11 single pulse", 32'(rsp_valid), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
    chk(bus_ale == 1'b0 && bus_ad_oe == 1'b0, "R2 reset ale/oe", 32'({bus_ale, bus_ad_oe}), 32'd0);
    chk({bus_rd_n, bus_wr_n, bus_inta_n} == 3'b111, "R4 reset strobes",
        32'({bus_rd_n, bus_wr_n, bus_inta_n}), 32'h7);
    chk(bus_stat == 3'b111, "R5 reset status", 32'(bus_stat), 32'h7);
    chk(rsp_valid == 1'b0, "R11 reset response", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(bus_stat == 3'b111 && req_ready == 1'b1, "R5 idle passive", 32'(bus_stat), 32'h7);

    for (int k = 0; k < 8; k++)
      for (int w = 0; w < 2; w++)
        for (int o = 0; o < 2; o++)
          for (int wt = 0; wt < 3; wt++) begin
            logic [19:0] base;
            base = 20'(32'h5A3C4 + k * 32'h1111 + wt * 32'h248);
            run_txn(k, w[0], {base[19:1], o[0]},
                    16'(32'hB7C1 + k * 32'h0F3 + wt * 32'h51 + o), wt);
          end
    run_txn(5, 1'b1, 20'hFFFFF, 16'h2468, 1);
    run_txn(6, 1'b1, 20'hFFFFF, 16'h1357, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule